// File: doc/BRIEF.md
# Logic Analyzer Sample Packer

This block sits between the probe sampling front end of a logic analyzer and the link that carries captured data to a host. On each sample strobe it records the level of every probe. Every 16 strobes form one time slice. At the end of a slice, each enabled probe has a 16-bit word with one bit per sample instant. The words go out on a byte-wide valid/ready stream. Probes are sent in ascending order and disabled probes are left out. Each word is sent as two bytes, and after the highest enabled probe the next slice begins again at the lowest enabled probe.

Capture and output overlap. While one slice drains from a holding buffer, the next slice is already being shifted in. The output must keep up or data is lost. Sending one slice takes two byte transfers per enabled probe, and one slice lasts 16 strobes. So with eight or fewer enabled probes a strobe on every clock can be sustained. With more probes the strobe rate has to drop in proportion.

Software raises a start control to begin a run and lowers it to end the run. The run always ends on a slice boundary.

Top module: `sample_packer`

## Requirements
- R1: After reset, `outValid` is 0 and `overflow` is 0.
- R2: Bit i of a probe's word is that probe's level at the i-th strobe of the slice (bit 0 is the earliest sample). A value of 1 means the probe was high.
- R3: Each word is sent as two bytes: first bits 7:0, then bits 15:8.
- R4: Within a slice, words are sent in ascending probe index. Probes whose bit in `enableMask` is 0 produce no bytes. Each slice produces exactly 2 × (number of enabled probes) bytes.
- R5: A slice is handed to the output only on the strobe that completes it. The next slice is captured while the previous one drains. With at most 8 enabled probes, a strobe every clock and `outReady` held high, no slice is lost.
- R6: A slice may complete while the previous slice still has bytes left beyond a final handshake in that same cycle. In that case the new slice is discarded and `overflow` goes to 1. The earlier slice is still sent intact. `overflow` stays 1 until the next run starts, where it returns to 0.
- R7: A run starts when `startEn` is 1 in idle. If `startEn` is 0 at the strobe that completes a slice, that slice is sent and no further slices are captured. The output then goes quiet.
- R8: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` stays unchanged on the next cycle.
- R9: `enableMask` is taken at run start. Changes to it during a run have no effect on that run's output.
- R10: A start request with `enableMask` equal to 0 does not begin a run and produces no bytes.
- R11: Sample strobes outside a run capture nothing and produce no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStrobe | input | 1 | One-cycle pulse: record the probe levels now |
| probes | input | 16 | Current probe levels, bit p for probe p |
| enableMask | input | 16 | Probes to include, taken at run start |
| startEn | input | 1 | Run request; lowering it ends the run at the next slice boundary |
| outData | output | 8 | Stream byte |
| outValid | output | 1 | Stream byte available |
| outReady | input | 1 | Sink accepts the byte this cycle |
| overflow | output | 1 | Sticky: a slice was lost during this run |

## Verification
The assertions check the stream contract on every cycle: valid and data are held under back-pressure. They also check that output and the overflow flag only ever start on a sample strobe, and that the flag is cleared only by a start request. Correct bit placement, byte order, probe ordering, skipping of disabled probes and mask latching cannot be seen from a single cycle. Neither can a clean stop on a slice boundary or the choice of which slice is lost on overflow. These show only in the bench's scenarios, where whole captured streams are compared against words built from the driven samples. Those scenarios sweep many masks, strobe spacings and ready patterns.

// File: rtl/packer_pkg.sv
package packer_pkg;

  parameter int NUM_PROBES = 16;
  parameter int SLICE_LEN  = 16;
  parameter int BYTE_W     = 8;

  localparam int IDX_W      = $clog2(NUM_PROBES);
  localparam int CNT_W      = $clog2(SLICE_LEN);
  localparam int WORD_BYTES = SLICE_LEN / BYTE_W;
  localparam int BSEL_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN
  } packState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              shiftEn;   // record current probe levels
    logic              loadHold;  // copy finished slice into the drain buffer
    logic [BSEL_W-1:0] byteIdx;   // byte of the current word on the output
    logic [IDX_W-1:0]  curProbe;  // probe whose word is on the output
  } packCtrl_t;

endpackage

// File: rtl/packer_ctrl.sv
module packer_ctrl
  import packer_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleStrobe,
  input  logic                  startEn,
  input  logic [NUM_PROBES-1:0] enableMask,
  input  logic                  outReady,
  output logic                  outValid,
  output logic                  overflow,
  output packCtrl_t             ctl
);

  packState_e state, stateNext;

  logic [CNT_W-1:0]      sampleCnt;
  logic [NUM_PROBES-1:0] runMask;
  logic [NUM_PROBES-1:0] pending;
  logic [NUM_PROBES-1:0] curOneHot;
  logic [NUM_PROBES-1:0] restMask;
  logic [IDX_W-1:0]      curIdx;
  logic [BSEL_W-1:0]     byteIdx;

  logic fire, wordDone, drainFree, sliceDone, loadSlice, runStart, capturing;

  // lowest pending probe is the one being sent
  always_comb begin
    curOneHot = pending & (~pending + NUM_PROBES'(1));
    restMask  = pending & ~curOneHot;
    curIdx    = '0;
    for (int i = NUM_PROBES - 1; i >= 0; i--) begin
      if (pending[i]) curIdx = IDX_W'(i);
    end
  end

  always_comb begin
    outValid  = |pending;
    fire      = outValid && outReady;
    wordDone  = fire && (byteIdx == BSEL_W'(WORD_BYTES - 1));
    // buffer is free now, or its very last byte leaves this cycle
    drainFree = !(|pending) || (wordDone && !(|restMask));
    capturing = (state == ST_RUN) && sampleStrobe;
    runStart  = (state == ST_IDLE) && startEn && (|enableMask);
    sliceDone = capturing && (sampleCnt == CNT_W'(SLICE_LEN - 1));
    loadSlice = sliceDone && drainFree;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (runStart) stateNext = ST_RUN;
      ST_RUN:   if (sliceDone && !startEn) stateNext = ST_DRAIN;
      ST_DRAIN: if (!(|pending)) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sampleCnt <= '0;
      runMask   <= '0;
      pending   <= '0;
      byteIdx   <= '0;
      overflow  <= 1'b0;
    end else begin
      state <= stateNext;

      if (runStart) begin
        runMask   <= enableMask;
        sampleCnt <= '0;
      end else if (capturing) begin
        sampleCnt <= sliceDone ? '0 : sampleCnt + CNT_W'(1);
      end

      if (loadSlice) begin
        pending <= runMask;
      end else if (wordDone) begin
        pending <= restMask;
      end

      if (fire) begin
        byteIdx <= wordDone ? '0 : byteIdx + BSEL_W'(1);
      end

      if (runStart) begin
        overflow <= 1'b0;
      end else if (sliceDone && !drainFree) begin
        overflow <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl.shiftEn  = capturing;
    ctl.loadHold = loadSlice;
    ctl.byteIdx  = byteIdx;
    ctl.curProbe = curIdx;
  end

endmodule

// File: rtl/packer_dp.sv
module packer_dp
  import packer_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PROBES-1:0] probes,
  input  packCtrl_t             ctl,
  output logic [BYTE_W-1:0]     outData
);

  logic [SLICE_LEN-1:0] capReg  [NUM_PROBES];
  logic [SLICE_LEN-1:0] capNext [NUM_PROBES];
  logic [SLICE_LEN-1:0] holdReg [NUM_PROBES];
  logic [SLICE_LEN-1:0] selWord;

  for (genvar p = 0; p < NUM_PROBES; p++) begin : gProbe
    // newest sample enters at the top, so the earliest ends in bit 0
    assign capNext[p] = {probes[p], capReg[p][SLICE_LEN-1:1]};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        capReg[p]  <= '0;
        holdReg[p] <= '0;
      end else begin
        if (ctl.shiftEn)  capReg[p]  <= capNext[p];
        if (ctl.loadHold) holdReg[p] <= capNext[p];
      end
    end
  end

  always_comb begin
    selWord = holdReg[ctl.curProbe];
    outData = selWord[int'(ctl.byteIdx) * BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/sample_packer.sv
module sample_packer
  import packer_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleStrobe,
  input  logic [NUM_PROBES-1:0] probes,
  input  logic [NUM_PROBES-1:0] enableMask,
  input  logic                  startEn,
  output logic [BYTE_W-1:0]     outData,
  output logic                  outValid,
  input  logic                  outReady,
  output logic                  overflow
);

  packCtrl_t ctl;

  packer_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleStrobe (sampleStrobe),
    .startEn      (startEn),
    .enableMask   (enableMask),
    .outReady     (outReady),
    .outValid     (outValid),
    .overflow     (overflow),
    .ctl          (ctl)
  );

  packer_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .probes  (probes),
    .ctl     (ctl),
    .outData (outData)
  );

endmodule

// File: rtl/packer_chk.sv
module packer_chk
  import packer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sampleStrobe,
  input logic              startEn,
  input logic [BYTE_W-1:0] outData,
  input logic              outValid,
  input logic              outReady,
  input logic              overflow
);

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid); // R8

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData)); // R8

  AST_OUT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(sampleStrobe)); // R5

  AST_OVF_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(sampleStrobe)); // R6

  AST_OVF_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overflow) |-> $past(startEn)); // R6

endmodule

bind sample_packer packer_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .sampleStrobe (sampleStrobe),
  .startEn      (startEn),
  .outData      (outData),
  .outValid     (outValid),
  .outReady     (outReady),
  .overflow     (overflow)
);

// File: tb/sim_sample_packer.sv
`timescale 1ns/100ps
module sim_sample_packer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStrobe = 1'b0;
  logic [15:0] probes = '0;
  logic [15:0] enableMask = '0;
  logic        startEn = 1'b0;
  logic [7:0]  outData;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        overflow;

  int checks = 0;
  int fails = 0;
  int readyMode = 0;   // 0 always ready, 1 pattern, 2 never
  int cyc = 0;

  logic [7:0] rx  [0:1023];
  logic [7:0] exp [0:1023];
  int rxCnt = 0;
  int expCnt = 0;

  always #2.5 clk = ~clk;

  sample_packer u0 (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .probes(probes),
    .enableMask(enableMask), .startEn(startEn), .outData(outData),
    .outValid(outValid), .outReady(outReady), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [15:0] samp(input int s, input int i, input int salt);
    int k;
    k = s * 16 + i + salt * 37 + 1;
    return 16'((k * 40503) ^ ((k * k) >> 5) ^ (salt << 3));
  endfunction

  // ready driver
  initial forever begin
    @(negedge clk);
    cyc++;
    case (readyMode)
      0: outReady = 1'b1;
      1: outReady = (cyc % 5) != 3;
      default: outReady = 1'b0;
    endcase
  end

  // monitor: sample late in the cycle, before the handshake edge
  logic       prevStall = 1'b0;
  logic [7:0] prevData = '0;
  initial forever begin
    @(posedge clk);
    #4;
    if (rstN) begin
      if (prevStall) begin
        check(outValid === 1'b1, "R8 valid held", int'(outValid), 1);
        check(outData === prevData, "R8 data held", int'(outData), int'(prevData));
      end
      if (outValid && outReady && rxCnt < 1024) begin
        rx[rxCnt] = outData;
        rxCnt++;
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
    end
  end

  // one run: start with mask, optionally change mask after first strobe
  task automatic runCase(input logic [15:0] mask, input logic [15:0] altMask,
                         input int nSlices, input int gap, input int runReady,
                         input int salt, input int expSlices, input bit expOvf);
    logic [15:0] w;
    rxCnt = 0;
    expCnt = 0;
    for (int s = 0; s < expSlices; s++) begin
      for (int p = 0; p < 16; p++) begin
        if (mask[p]) begin
          for (int i = 0; i < 16; i++) w[i] = samp(s, i, salt)[p];
          exp[expCnt] = w[7:0];  expCnt++;   // R3 low byte first
          exp[expCnt] = w[15:8]; expCnt++;
        end
      end
    end
    readyMode = runReady;
    @(negedge clk);
    enableMask = mask;
    startEn = 1'b1;
    @(negedge clk);
    for (int s = 0; s < nSlices; s++) begin
      for (int i = 0; i < 16; i++) begin
        if (s == nSlices - 1 && i == 0) startEn = 1'b0;
        probes = samp(s, i, salt);
        sampleStrobe = 1'b1;
        @(negedge clk);
        sampleStrobe = 1'b0;
        if (s == 0 && i == 0) enableMask = altMask;   // R9
        repeat (gap - 1) @(negedge clk);
      end
    end
    readyMode = (runReady == 2) ? 0 : runReady;
    repeat (120) @(negedge clk);
    check(overflow === expOvf, "R6 overflow flag", int'(overflow), int'(expOvf));
    check(outValid === 1'b0, "R7 quiet after stop", int'(outValid), 0);
    check(rxCnt == expCnt, "R4 R7 byte count", rxCnt, expCnt);
    for (int b = 0; b < expCnt && b < rxCnt; b++)
      check(rx[b] === exp[b], "R2 R3 R4 byte value", int'(rx[b]), int'(exp[b]));
    // R11: strobes after the run are ignored
    for (int i = 0; i < 20; i++) begin
      probes = 16'hFFFF;
      sampleStrobe = 1'b1;
      @(negedge clk);
    end
    sampleStrobe = 1'b0;
    repeat (40) @(negedge clk);
    check(rxCnt == expCnt && outValid === 1'b0, "R11 idle strobes ignored", rxCnt, expCnt);
  endtask

  initial begin
    logic [15:0] m;
    repeat (4) @(negedge clk);
    check(outValid === 1'b0, "R1 reset valid", int'(outValid), 0);
    check(overflow === 1'b0, "R1 reset overflow", int'(overflow), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0 && overflow === 1'b0, "R1 after release", int'(outValid), 0);

    // each probe alone
    for (int p = 0; p < 16; p++) begin
      m = 16'h1 << p;
      runCase(m, m, 2, 4, 1, p, 2, 1'b0);
    end
    // three, six, nine and sixteen probes
    runCase(16'h0007, 16'h0007, 2, 4, 1, 20, 2, 1'b0);
    runCase(16'h8421, 16'h8421, 2, 4, 1, 21, 2, 1'b0);
    runCase(16'h0A3C, 16'h0A3C, 2, 4, 1, 22, 2, 1'b0);
    runCase(16'h01FF, 16'h01FF, 3, 2, 1, 23, 3, 1'b0);
    runCase(16'hB5A1, 16'hB5A1, 2, 4, 1, 24, 2, 1'b0);
    runCase(16'hFFFF, 16'hFFFF, 2, 4, 1, 25, 2, 1'b0);
    runCase(16'hFFFF, 16'hFFFF, 1, 3, 0, 26, 1, 1'b0);
    // R5 full rate with eight or fewer probes
    runCase(16'h00FF, 16'h00FF, 3, 1, 0, 30, 3, 1'b0);
    runCase(16'h5555, 16'h5555, 3, 1, 0, 31, 3, 1'b0);
    runCase(16'h8001, 16'h8001, 4, 1, 0, 32, 4, 1'b0);
    // R9 mask change during run has no effect
    runCase(16'h0F0F, 16'hF0F0, 2, 4, 1, 40, 2, 1'b0);
    // R6 overflow: sink stalled, second slice lost, flag sticky
    runCase(16'hFFFF, 16'hFFFF, 2, 1, 2, 50, 1, 1'b1);
    check(overflow === 1'b1, "R6 overflow sticky", int'(overflow), 1);
    // nine probes at full rate cannot keep up
    runCase(16'h01FF, 16'h01FF, 2, 1, 0, 51, 1, 1'b1);
    // R6 next start clears the flag
    runCase(16'h0003, 16'h0003, 1, 2, 1, 52, 1, 1'b0);
    // R10 zero mask never starts
    runCase(16'h0000, 16'h0000, 2, 1, 0, 60, 0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule